// File: doc/BRIEF.md
# Supervisor Timer Compare Unit

This block holds the supervisor timer compare value and, when hypervisor support is built in, a second compare value for the virtual-supervisor level. It compares a free-running time input against each value and drives the matching timer pending line. A machine-level timer enable bit decides how the pending lines are produced. When the bit is set, each line is a read-only compare result. When it is clear, each line is a plain bit that machine software writes. A hypervisor-level enable bit applies the same rule to the virtual line. It can only be set while the machine bit is set.

CSR accesses reach the block through one request port. The port carries the current privilege, a register selector, a write flag and write data. Read data is combinational on the selector. A disallowed access writes nothing and gives a one-cycle illegal-instruction pulse. The time counter and the trap logic that consumes the pulse sit outside the block.

Top module: `stc_top`

## Requirements
- R1: After reset both pending outputs and `illegal_o` are 0, both enable bits read 0, and both compare registers read all ones.
- R2: While the machine enable is 1, `stip_o` equals the unsigned 64-bit result of (time >= supervisor compare). It follows the inputs with one register stage.
- R3: While the machine enable is 1, a machine write to the pending selector (4) has no effect on `stip_o`.
- R4: While the machine enable is 0, `stip_o` equals bit 0 last written by machine software to selector 4.
- R5: When the machine enable goes from 1 to 0, `stip_o` takes the value stored in the software bit, which is not changed by writes made while enabled.
- R6: While the machine enable is 0, any access to selector 0 (supervisor compare) or 1 (virtual compare) from a privilege other than machine (code 3) raises `illegal_o` for exactly one cycle, one cycle after the request. Nothing is written.
- R7: A machine-privilege access to either compare register is always legal, whatever the enable bits.
- R8: The hypervisor enable (selector 3, bit 0) reads 0 and cannot be set while the machine enable (selector 2, bit 0) is 0. Clearing the machine enable also clears it.
- R9: With the hypervisor enable at 1, `vstip_o` is (time + offset >= virtual compare), unsigned and modulo 2^64. With it at 0, `vstip_o` is bit 1 last written by machine software to selector 4.
- R10: Selectors 2 and 4 are legal only from machine privilege. Selector 3 is legal from any privilege except user (code 0). Selectors 5 to 7 are always illegal. Illegal accesses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| time_i | input | 64 | Free-running time value |
| toff_i | input | 64 | Time offset added for the virtual comparison |
| priv_i | input | 2 | Privilege of the access: 0 user, 1 supervisor, 3 machine |
| csr_req_i | input | 1 | Access request, one cycle per access |
| csr_we_i | input | 1 | Access is a write |
| csr_sel_i | input | 3 | 0 sup compare, 1 virt compare, 2 machine enable, 3 hyp enable, 4 pending |
| csr_wdata_i | input | 64 | Write data |
| csr_rdata_o | output | 64 | Read data for the selected register (pending: bit0 stip, bit1 vstip) |
| illegal_o | output | 1 | One-cycle illegal-instruction pulse |
| stip_o | output | 1 | Supervisor timer pending |
| vstip_o | output | 1 | Virtual-supervisor timer pending |

## Verification
The bench targets the equality point time == compare and the point one below it. A design using `>` instead of `>=` would miss the equality point and raise the interrupt one tick late. It also uses compare values with the top bit set, where a signed comparison would assert the interrupt decades early. It drives a sequence that disables the machine enable after the software bit was written under enable; a design that let enabled writes through, or loaded the compare result into the software bit, would show the wrong level. Lower-privilege accesses to the compare registers while disabled must pulse the illegal flag and leave the register unchanged, and the hypervisor enable must stay zero across a disable and re-enable of the machine bit.

// File: rtl/stc_pkg.sv
package stc_pkg;
  typedef enum logic [2:0] {
    SEL_SCMP  = 3'd0,
    SEL_VSCMP = 3'd1,
    SEL_MCFG  = 3'd2,
    SEL_HCFG  = 3'd3,
    SEL_PEND  = 3'd4
  } stc_sel_e;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;
endpackage

// File: rtl/stc_access_ctl.sv
module stc_access_ctl
  import stc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_i,
  input  logic       we_i,
  input  logic [1:0] priv_i,
  input  logic [2:0] sel_i,
  input  logic       men_i,
  output logic       wr_scmp_o,
  output logic       wr_vscmp_o,
  output logic       wr_mcfg_o,
  output logic       wr_hcfg_o,
  output logic       wr_pend_o,
  output logic       illegal_o
);
  logic is_m;
  logic legal;
  logic ill_d, ill_q;
  logic wr_ok;

  assign is_m = (priv_i == PRIV_M);

  always_comb begin
    case (sel_i)
      SEL_SCMP, SEL_VSCMP: legal = is_m | men_i;
      SEL_MCFG, SEL_PEND:  legal = is_m;
      SEL_HCFG:            legal = (priv_i != PRIV_U);
      default:             legal = 1'b0;
    endcase
  end

  assign wr_ok      = req_i & we_i & legal;
  assign wr_scmp_o  = wr_ok & (sel_i == SEL_SCMP);
  assign wr_vscmp_o = wr_ok & (sel_i == SEL_VSCMP);
  assign wr_mcfg_o  = wr_ok & (sel_i == SEL_MCFG);
  assign wr_hcfg_o  = wr_ok & (sel_i == SEL_HCFG);
  assign wr_pend_o  = wr_ok & (sel_i == SEL_PEND);

  assign ill_d = req_i & ~legal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ill_q <= 1'b0;
    else        ill_q <= ill_d;
  end

  assign illegal_o = ill_q;

  // Machine-privilege accesses to the compare registers never trap
  assert_m_cmp_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> !($past(priv_i) == PRIV_M && $past(sel_i) <= 3'd1));

  // Disallowed pulse stems from a request in the previous cycle
  assert_ill_from_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $past(req_i));
endmodule

// File: rtl/stc_cmp_unit.sv
module stc_cmp_unit #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         gate_en_i,
  input  logic [W-1:0] time_i,
  input  logic         cmp_we_i,
  input  logic [W-1:0] cmp_wdata_i,
  input  logic         sw_we_i,
  input  logic         sw_wdata_i,
  output logic [W-1:0] cmp_o,
  output logic         pend_o
);
  logic [W-1:0] cmp_d, cmp_q;
  logic         sw_d, sw_q;
  logic         pend_d, pend_q;
  logic         hit;

  assign hit = (time_i >= cmp_q);

  always_comb begin
    cmp_d  = cmp_we_i ? cmp_wdata_i : cmp_q;
    sw_d   = sw_we_i ? sw_wdata_i : sw_q;
    pend_d = gate_en_i ? hit : sw_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmp_q  <= '1;
      sw_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cmp_q  <= cmp_d;
      sw_q   <= sw_d;
      pend_q <= pend_d;
    end
  end

  assign cmp_o  = cmp_q;
  assign pend_o = pend_q;

  // Gated-on pending reflects last cycle's compare (R2 for supervisor, R9 for virtual)
  assert_cmp_drive_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(gate_en_i) && $stable(cmp_q)) |-> (pend_o == ($past(time_i) >= cmp_q)));

  // Gated-off pending follows the stored software bit (R4, R9)
  assert_sw_drive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!gate_en_i) |-> (pend_o == $past(sw_q)));
endmodule

// File: rtl/stc_top.sv
module stc_top
  import stc_pkg::*;
#(
  parameter int W       = 64,
  parameter bit HAS_HYP = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] time_i,
  input  logic [W-1:0] toff_i,
  input  logic [1:0]   priv_i,
  input  logic         csr_req_i,
  input  logic         csr_we_i,
  input  logic [2:0]   csr_sel_i,
  input  logic [W-1:0] csr_wdata_i,
  output logic [W-1:0] csr_rdata_o,
  output logic         illegal_o,
  output logic         stip_o,
  output logic         vstip_o
);
  logic wr_scmp, wr_vscmp, wr_mcfg, wr_hcfg, wr_pend;
  logic men_d, men_q, hen_d, hen_q;
  logic [W-1:0] scmp_val, vscmp_val;

  stc_access_ctl u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (csr_req_i),
    .we_i       (csr_we_i),
    .priv_i     (priv_i),
    .sel_i      (csr_sel_i),
    .men_i      (men_q),
    .wr_scmp_o  (wr_scmp),
    .wr_vscmp_o (wr_vscmp),
    .wr_mcfg_o  (wr_mcfg),
    .wr_hcfg_o  (wr_hcfg),
    .wr_pend_o  (wr_pend),
    .illegal_o  (illegal_o)
  );

  always_comb begin
    men_d = wr_mcfg ? csr_wdata_i[0] : men_q;
    if (!men_d)       hen_d = 1'b0;
    else if (wr_hcfg) hen_d = csr_wdata_i[0];
    else              hen_d = hen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      men_q <= 1'b0;
      hen_q <= 1'b0;
    end else begin
      men_q <= men_d;
      hen_q <= hen_d;
    end
  end

  stc_cmp_unit #(.W(W)) u_sup (
    .clk         (clk),
    .rst_n       (rst_n),
    .gate_en_i   (men_q),
    .time_i      (time_i),
    .cmp_we_i    (wr_scmp),
    .cmp_wdata_i (csr_wdata_i),
    .sw_we_i     (wr_pend & ~men_q),
    .sw_wdata_i  (csr_wdata_i[0]),
    .cmp_o       (scmp_val),
    .pend_o      (stip_o)
  );

  generate
    if (HAS_HYP) begin : g_virt
      logic [W-1:0] vtime;
      assign vtime = time_i + toff_i;
      stc_cmp_unit #(.W(W)) u_virt (
        .clk         (clk),
        .rst_n       (rst_n),
        .gate_en_i   (hen_q),
        .time_i      (vtime),
        .cmp_we_i    (wr_vscmp),
        .cmp_wdata_i (csr_wdata_i),
        .sw_we_i     (wr_pend & ~hen_q),
        .sw_wdata_i  (csr_wdata_i[1]),
        .cmp_o       (vscmp_val),
        .pend_o      (vstip_o)
      );
    end else begin : g_novirt
      logic unused_virt;
      assign unused_virt = ^{toff_i, wr_vscmp};
      assign vscmp_val   = '0;
      assign vstip_o     = 1'b0;
    end
  endgenerate

  always_comb begin
    csr_rdata_o = '0;
    case (csr_sel_i)
      SEL_SCMP:  csr_rdata_o = scmp_val;
      SEL_VSCMP: csr_rdata_o = vscmp_val;
      SEL_MCFG:  csr_rdata_o[0] = men_q;
      SEL_HCFG:  csr_rdata_o[0] = hen_q;
      SEL_PEND:  csr_rdata_o[1:0] = {vstip_o, stip_o};
      default:   csr_rdata_o = '0;
    endcase
  end

  // A trapped access leaves the supervisor compare untouched
  assert_ill_noupd_R6: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_o |-> $stable(scmp_val));

  // Hypervisor enable never set while machine enable is clear
  assert_hen_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !men_q |-> !hen_q);

  // Pulse lasts one cycle when no new request arrived
  assert_ill_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (illegal_o && !csr_req_i) |=> !illegal_o);
endmodule

// File: tb/sim_stc_top.sv
module sim_stc_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] time_i, toff_i, csr_wdata_i, csr_rdata_o;
  logic [1:0]  priv_i;
  logic        csr_req_i, csr_we_i;
  logic [2:0]  csr_sel_i;
  logic        illegal_o, stip_o, vstip_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  // bench model state
  bit          m_men, m_hen, m_sw0, m_sw1;
  logic [63:0] m_scmp, m_vscmp;

  stc_top u0 (
    .clk(clk), .rst_n(rst_n), .time_i(time_i), .toff_i(toff_i),
    .priv_i(priv_i), .csr_req_i(csr_req_i), .csr_we_i(csr_we_i),
    .csr_sel_i(csr_sel_i), .csr_wdata_i(csr_wdata_i), .csr_rdata_o(csr_rdata_o),
    .illegal_o(illegal_o), .stip_o(stip_o), .vstip_o(vstip_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit legal_f(logic [1:0] p, logic [2:0] s, bit men);
    case (s)
      3'd0, 3'd1: return (p == 2'd3) || men;
      3'd2, 3'd4: return p == 2'd3;
      3'd3:       return p != 2'd0;
      default:    return 1'b0;
    endcase
  endfunction

  function automatic bit exp_stip();
    return m_men ? (time_i >= m_scmp) : m_sw0;
  endfunction

  function automatic bit exp_vstip();
    return m_hen ? ((time_i + toff_i) >= m_vscmp) : m_sw1;
  endfunction

  function automatic logic [63:0] exp_rd(logic [2:0] s);
    case (s)
      3'd0: return m_scmp;
      3'd1: return m_vscmp;
      3'd2: return {63'd0, m_men};
      3'd3: return {63'd0, m_hen};
      3'd4: return {62'd0, exp_vstip(), exp_stip()};
      default: return 64'd0;
    endcase
  endfunction

  task automatic check_pend(string req);
    check({req, " stip"}, {63'd0, stip_o}, {63'd0, exp_stip()});
    check("R9 vstip", {63'd0, vstip_o}, {63'd0, exp_vstip()});
  endtask

  task automatic do_op(logic [1:0] p, logic [2:0] s, bit we, logic [63:0] wd, string req);
    bit lg;
    lg = legal_f(p, s, m_men);
    @(negedge clk);
    priv_i = p; csr_sel_i = s; csr_we_i = we; csr_wdata_i = wd; csr_req_i = 1'b1;
    #1;
    if (!we && s <= 3'd4) check({req, " read"}, csr_rdata_o, exp_rd(s));
    @(negedge clk);
    csr_req_i = 1'b0;
    check({req, " illegal"}, {63'd0, illegal_o}, {63'd0, !lg});
    if (lg && we) begin
      case (s)
        3'd0: m_scmp = wd;
        3'd1: m_vscmp = wd;
        3'd2: begin m_men = wd[0]; if (!wd[0]) m_hen = 1'b0; end
        3'd3: m_hen = wd[0] & m_men;
        3'd4: begin if (!m_men) m_sw0 = wd[0]; if (!m_hen) m_sw1 = wd[1]; end
        default: ;
      endcase
    end
    @(negedge clk);
    check({req, " pulse end"}, {63'd0, illegal_o}, 64'd0);
    check_pend(req);
  endtask

  task automatic set_time(logic [63:0] t, string req);
    @(negedge clk);
    time_i = t;
    @(negedge clk);
    @(negedge clk);
    check_pend(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; time_i = '0; toff_i = '0; priv_i = 2'd0;
    csr_req_i = 1'b0; csr_we_i = 1'b0; csr_sel_i = 3'd0; csr_wdata_i = '0;
    m_men = 0; m_hen = 0; m_sw0 = 0; m_sw1 = 0; m_scmp = '1; m_vscmp = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 stip", {63'd0, stip_o}, 64'd0);
    check("R1 vstip", {63'd0, vstip_o}, 64'd0);
    check("R1 illegal", {63'd0, illegal_o}, 64'd0);
    csr_sel_i = 3'd0; #1 check("R1 scmp", csr_rdata_o, '1);
    csr_sel_i = 3'd1; #1 check("R1 vscmp", csr_rdata_o, '1);
    csr_sel_i = 3'd2; #1 check("R1 men", csr_rdata_o, 64'd0);
    csr_sel_i = 3'd3; #1 check("R1 hen", csr_rdata_o, 64'd0);

    // R7 machine writes compare while disabled, R2 boundaries
    do_op(2'd3, 3'd0, 1, 64'd100, "R7");
    do_op(2'd3, 3'd2, 1, 64'd1, "R2 enable");
    set_time(64'd99, "R2 below");
    set_time(64'd100, "R2 equal");
    set_time(64'd101, "R2 above");
    set_time(64'd99, "R2 back");
    // R3 write ignored while enabled
    do_op(2'd3, 3'd4, 1, 64'd1, "R3");
    set_time(64'd98, "R3 hold");
    // unsigned compare with top bit set
    do_op(2'd3, 3'd0, 1, 64'h8000_0000_0000_0000, "R2 msb");
    set_time(64'h7FFF_FFFF_FFFF_FFFF, "R2 unsigned lo");
    set_time(64'h8000_0000_0000_0000, "R2 unsigned eq");
    // R6 disabled lower-privilege access traps
    do_op(2'd1, 3'd0, 1, 64'd5, "R7 sup legal when enabled");
    do_op(2'd3, 3'd2, 1, 64'd0, "R4 disable");
    do_op(2'd1, 3'd0, 1, 64'd77, "R6 sup write");
    do_op(2'd3, 3'd0, 0, 64'd0, "R6 no update");
    do_op(2'd0, 3'd1, 0, 64'd0, "R6 user read");
    do_op(2'd3, 3'd1, 1, 64'd9, "R7 machine vscmp");
    // R4/R5 software bit, retention across enable toggle
    do_op(2'd3, 3'd4, 1, 64'd1, "R4 sw set");
    do_op(2'd3, 3'd0, 1, 64'd1000, "R5 cmp");
    set_time(64'd10, "R5 t");
    do_op(2'd3, 3'd2, 1, 64'd1, "R5 enable");
    do_op(2'd3, 3'd4, 1, 64'd0, "R5 ignored write");
    do_op(2'd3, 3'd2, 1, 64'd0, "R5 disable");
    do_op(2'd3, 3'd4, 1, 64'd0, "R4 sw clear");
    // R8 hypervisor enable gating
    do_op(2'd3, 3'd3, 1, 64'd1, "R8 set blocked");
    do_op(2'd3, 3'd3, 0, 64'd0, "R8 read zero");
    do_op(2'd3, 3'd2, 1, 64'd1, "R8 men on");
    do_op(2'd1, 3'd3, 1, 64'd1, "R8 set ok");
    do_op(2'd0, 3'd3, 1, 64'd0, "R10 user hcfg");
    do_op(2'd1, 3'd2, 1, 64'd0, "R10 sup mcfg");
    do_op(2'd3, 3'd6, 0, 64'd0, "R10 bad sel");
    // R9 virtual compare with offset
    toff_i = 64'd20;
    do_op(2'd3, 3'd1, 1, 64'd50, "R9 vcmp");
    set_time(64'd30, "R9 equal");
    set_time(64'd29, "R9 below");
    do_op(2'd3, 3'd2, 1, 64'd0, "R8 men off");
    do_op(2'd3, 3'd2, 1, 64'd1, "R8 men on again");
    do_op(2'd3, 3'd3, 0, 64'd0, "R8 stays clear");

    // constrained random
    for (int i = 0; i < 800; i++) begin
      logic [1:0] p;
      logic [2:0] s;
      logic [63:0] base, wd;
      int k;
      k = $urandom % 4;
      p = (k == 3) ? 2'd3 : ((k == 2) ? 2'd3 : k[1:0]);
      s = ($urandom % 10 == 0) ? 3'($urandom % 8) : 3'($urandom % 5);
      base = {$urandom, $urandom};
      if ($urandom % 3 == 0) base[63] = ~base[63];
      if (i % 7 == 0) begin
        toff_i = {32'd0, $urandom % 16};
        set_time(base, "R2 rand time");
      end
      if (s <= 3'd1) wd = time_i + 64'($signed(6'($urandom % 64)) ) - 64'd16;
      else           wd = {62'd0, 2'($urandom % 4)};
      do_op(p, s, ($urandom % 3) != 0, wd, "R6 rand");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule